// File: doc/BRIEF.md
# Timer Compare Channel with Period Trigger

This block pairs a free-running up-counter with one compare channel. Software loads a compare value and a 4-bit action mode through a small write port. On every clock in which the counter is enabled, the channel checks whether the counter equals the compare value. When they match, the selected action is applied. The action can set the compare output latch high, clear it low, or leave it alone and only raise the interrupt flag. It can also fire a period trigger, which restarts the counter from zero and requests a conversion from a downstream converter.

In trigger mode the compare value works as a programmable period: the counter runs from zero to the compare value and then restarts. A match that fires the trigger does not count as a counter overflow. Writing a mode of zero turns the channel off and forces its output latch low. The counter is assumed to run synchronously with the system clock.

Top module: `cmp_trig_unit`

## Requirements
- R1: While `cnt_en` is high the counter advances by one per clock, and while it is low the counter holds. A step from all ones to zero sets `ovf_flag`, which stays set until `ovf_clr` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R2: A write with `wr_sel`=0 loads `wr_data` into the compare value. A write with `wr_sel`=1 loads `wr_data[3:0]` into the mode. Both take effect at the next clock edge.
- R3: A match occurs only in a cycle where `cnt_en` is high, the mode is not zero, and `count` equals the compare value in all bits.
- R4: On a match in mode 4'b1000, `cmp_out` is 1 from the next clock. On a match in mode 4'b1001, `cmp_out` is 0 from the next clock.
- R5: Every match sets `irq_flag` at the next clock. The flag stays set until `irq_clr` is high. If a set and a clear arrive in the same cycle, the set wins.
- R6: In mode 4'b1010, and in every nonzero mode other than 4'b1000, 4'b1001 and 4'b1011, a match sets only the interrupt flag and leaves `cmp_out` unchanged.
- R7: On a match in mode 4'b1011, `count` is zero at the next clock, so the counting period is the compare value plus one.
- R8: A match in mode 4'b1011 produces a one-clock `conv_start` pulse at the next clock, but only if `conv_en` was high in the match cycle.
- R9: A trigger match never sets `ovf_flag`, even when the compare value is all ones.
- R10: Writing the mode to zero forces `cmp_out` to 0 at the next clock, and this write takes priority over a match in the same cycle.
- R11: While `rst_n` is low, `count`, `cmp_out`, `irq_flag`, `ovf_flag` and `conv_start` are all 0, and the compare value and mode are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter run enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the compare value, 1 selects the mode |
| wr_data | input | 16 | Write data |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| conv_en | input | 1 | Allows the trigger to request a conversion |
| count | output | 16 | Current counter value |
| cmp_out | output | 1 | Compare output latch |
| irq_flag | output | 1 | Channel interrupt flag |
| ovf_flag | output | 1 | Counter overflow flag |
| conv_start | output | 1 | One-clock conversion request |

## Verification
The channel is run under the set-high and clear-low modes, the software-interrupt mode and an undefined nonzero mode, with `cnt_en` held steady and also toggled at random. These runs show whether a match depends on the counter moving, and whether only the pin-driving modes touch the latch. Trigger mode is run with a small period and with conversion allowed and blocked, which separates the counter restart from the conversion request. A full wrap in the off mode, followed by a full-scale trigger period, shows that an overflow and a trigger restart set different flags. A clear held high across a match, and a zero mode write while the latch is high, test the two priority rules.

// File: rtl/cmp_trig_pkg.sv
package cmp_trig_pkg;

   localparam logic [3:0] MODE_OFF  = 4'b0000;
   localparam logic [3:0] MODE_SET  = 4'b1000;
   localparam logic [3:0] MODE_CLR  = 4'b1001;
   localparam logic [3:0] MODE_SWI  = 4'b1010;
   localparam logic [3:0] MODE_TRIG = 4'b1011;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_HIGH = 2'd1,
      ACT_LOW  = 2'd2,
      ACT_TRIG = 2'd3
   } act_e;

   function automatic act_e decode_mode(input logic [3:0] m);
      case (m)
         MODE_SET:  return ACT_HIGH;
         MODE_CLR:  return ACT_LOW;
         MODE_TRIG: return ACT_TRIG;
         default:   return ACT_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cmp_trig_counter.sv
module cmp_trig_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             ovf_clr,
   output logic [WIDTH-1:0] cnt,
   output logic             ovf
);

   localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cmp_trig_counter: WIDTH must be at least 2");
      end
   endgenerate

   logic wrap;
   assign wrap = en && !clr && (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (wrap)    ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt)); // R1
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R7
   AST_TRIG_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ovf) |=> !ovf); // R9

endmodule

// File: rtl/cmp_trig_match.sv
module cmp_trig_match #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] cnt,
   input  logic [WIDTH-1:0] ref_val,
   input  logic             active,
   input  logic             running,
   output logic             hit
);

   localparam int LANES = WIDTH / 8;

   generate
      if ((WIDTH % 8) != 0) begin : g_bad_width
         $error("cmp_trig_match: WIDTH must be a multiple of 8");
      end
   endgenerate

   logic [LANES-1:0] lane_eq;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_eq[i] = (cnt[i*8 +: 8] == ref_val[i*8 +: 8]);
      end
   endgenerate

   assign hit = active && running && (&lane_eq);

endmodule

// File: rtl/cmp_trig_action.sv
module cmp_trig_action
   import cmp_trig_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  act_e act,
   input  logic force_low,
   input  logic irq_clr,
   input  logic conv_en,
   output logic pin,
   output logic irq,
   output logic conv
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pin <= 1'b0;
      else if (force_low)                pin <= 1'b0;
      else if (hit && act == ACT_HIGH)   pin <= 1'b1;
      else if (hit && act == ACT_LOW)    pin <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq <= 1'b0;
      else if (hit)     irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) conv <= 1'b0;
      else        conv <= hit && (act == ACT_TRIG) && conv_en;
   end

   AST_IRQ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> irq); // R5
   AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      force_low |=> !pin); // R10
   AST_CONV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      conv |-> $past(conv_en)); // R8
   AST_PIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_low && act != ACT_HIGH && act != ACT_LOW) |=> $stable(pin)); // R6

endmodule

// File: rtl/cmp_trig_unit.sv
module cmp_trig_unit
   import cmp_trig_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int MODE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             irq_clr,
   input  logic             ovf_clr,
   input  logic             conv_en,
   output logic [WIDTH-1:0] count,
   output logic             cmp_out,
   output logic             irq_flag,
   output logic             ovf_flag,
   output logic             conv_start
);

   generate
      if (MODE_W != 4) begin : g_bad_mode
         $error("cmp_trig_unit: MODE_W must be 4");
      end
      if (WIDTH < MODE_W) begin : g_bad_width
         $error("cmp_trig_unit: WIDTH must hold the mode field");
      end
   endgenerate

   logic [WIDTH-1:0]  cmp_val;
   logic [MODE_W-1:0] mode;
   logic              hit;
   logic              trig;
   logic              zero_wr;
   act_e              act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '0;
         mode    <= MODE_OFF;
      end else if (wr_en) begin
         if (wr_sel) mode    <= wr_data[MODE_W-1:0];
         else        cmp_val <= wr_data;
      end
   end

   assign act     = decode_mode(mode);
   assign zero_wr = wr_en && wr_sel && (wr_data[MODE_W-1:0] == '0);
   assign trig    = hit && (act == ACT_TRIG);

   cmp_trig_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cnt_en),
      .clr     (trig),
      .ovf_clr (ovf_clr),
      .cnt     (count),
      .ovf     (ovf_flag)
   );

   cmp_trig_match #(.WIDTH(WIDTH)) u_match (
      .cnt     (count),
      .ref_val (cmp_val),
      .active  (mode != MODE_OFF),
      .running (cnt_en),
      .hit     (hit)
   );

   cmp_trig_action u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .act       (act),
      .force_low (zero_wr),
      .irq_clr   (irq_clr),
      .conv_en   (conv_en),
      .pin       (cmp_out),
      .irq       (irq_flag),
      .conv      (conv_start)
   );

   AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cnt_en && count == cmp_val)); // R3
   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (mode == $past(wr_data[MODE_W-1:0]))); // R2

endmodule

// File: tb/cmp_trig_unit_test.sv
`timescale 1ns/1ps
module cmp_trig_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        irq_clr = 1'b0, ovf_clr = 1'b0, conv_en = 1'b0;
   logic [15:0] count;
   logic        cmp_out, irq_flag, ovf_flag, conv_start;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference model state
   int       m_cnt = 0, m_cmp = 0, m_mode = 0;
   bit       m_out = 0, m_irq = 0, m_ovf = 0, m_conv = 0;

   always #5 clk = ~clk;

   cmp_trig_unit uut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr),
      .ovf_clr(ovf_clr), .conv_en(conv_en), .count(count),
      .cmp_out(cmp_out), .irq_flag(irq_flag), .ovf_flag(ovf_flag),
      .conv_start(conv_start)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural model, advanced at every rising edge from the inputs
   always @(posedge clk) begin
      bit hit, trg;
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_mode = 0;
         m_out = 0; m_irq = 0; m_ovf = 0; m_conv = 0;
      end else begin
         hit = cnt_en && (m_mode != 0) && (m_cnt == m_cmp);
         trg = hit && (m_mode == 11);
         m_conv = trg && conv_en;
         if (cnt_en && !trg && m_cnt == 65535) m_ovf = 1;
         else if (ovf_clr) m_ovf = 0;
         if (wr_en && wr_sel && wr_data[3:0] == 0) m_out = 0;
         else if (hit && m_mode == 8) m_out = 1;
         else if (hit && m_mode == 9) m_out = 0;
         if (hit) m_irq = 1;
         else if (irq_clr) m_irq = 0;
         if (trg) m_cnt = 0;
         else if (cnt_en) m_cnt = (m_cnt + 1) % 65536;
         if (wr_en) begin
            if (wr_sel) m_mode = int'(wr_data[3:0]);
            else m_cmp = int'(wr_data);
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      chk("R1/R7 count", int'(count), m_cnt);
      chk("R4/R6/R10 cmp_out", int'(cmp_out), int'(m_out));
      chk("R5 irq_flag", int'(irq_flag), int'(m_irq));
      chk("R1/R9 ovf_flag", int'(ovf_flag), int'(m_ovf));
      chk("R8 conv_start", int'(conv_start), int'(m_conv));
   end

   task automatic step(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr(input bit sel, input logic [15:0] d);
      wr_sel = sel; wr_data = d; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int first, gap;
      step(3);
      chk("R11 reset count", int'(count), 0);
      chk("R11 reset cmp_out", int'(cmp_out), 0);
      chk("R11 reset conv_start", int'(conv_start), 0);
      rst_n = 1'b1;
      step(2);

      // R4 set high on match, R2 loads, R3 requires running counter
      wr(1'b0, 16'd20);
      wr(1'b1, 16'h0008);
      cnt_en = 1'b1;
      step(40);
      chk("R4 set-high latch", int'(cmp_out), 1);
      chk("R5 irq after match", int'(irq_flag), 1);
      irq_clr = 1'b1; step(); irq_clr = 1'b0;

      // R4 clear low
      wr(1'b0, count + 16'd10);
      wr(1'b1, 16'h0009);
      step(20);
      chk("R4 clear-low latch", int'(cmp_out), 0);

      // R6 software-interrupt mode leaves pin high
      wr(1'b1, 16'h0008);
      wr(1'b0, count + 16'd10);
      step(20);
      wr(1'b1, 16'h000A);
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
      wr(1'b0, count + 16'd10);
      step(20);
      chk("R6 swi pin kept", int'(cmp_out), 1);
      chk("R6 swi irq set", int'(irq_flag), 1);

      // R6 undefined mode, with R5 clear held across the match
      wr(1'b1, 16'h0006);
      wr(1'b0, count + 16'd8);
      irq_clr = 1'b1;
      step(20);
      irq_clr = 1'b0;
      step(2);
      chk("R5 clear after set", int'(irq_flag), 0);
      chk("R6 other mode pin kept", int'(cmp_out), 1);

      // R10 zero mode write forces low
      wr(1'b1, 16'h0000);
      chk("R10 off forces low", int'(cmp_out), 0);

      // R3 stopped counter at compare value: no match
      wr(1'b0, count + 16'd3);
      wr(1'b1, 16'h0008);
      step(1);
      cnt_en = 1'b0;
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
      step(10);
      cnt_en = 1'b1;
      step(10);

      // R7/R8 trigger mode, period compare+1
      conv_en = 1'b1;
      wr(1'b0, 16'd5);
      wr(1'b1, 16'h000B);
      step(70000 - 0 > 0 ? 1 : 1);
      first = -1; gap = 0;
      for (int i = 0; i < 80000 && gap == 0; i++) begin
         step();
         if (conv_start) begin
            if (first < 0) first = i;
            else gap = i - first;
         end
      end
      chk("R7 trigger period", gap, 6);
      conv_en = 1'b0;
      step(30);
      chk("R8 no pulse without enable", int'(conv_start), 0);

      // random run enable across set/clear modes
      for (int k = 0; k < 200; k++) begin
         cnt_en = 1'($urandom_range(0, 1));
         if (k % 50 == 0) wr(1'b1, (k % 100 == 0) ? 16'h0008 : 16'h0009);
         if (k % 25 == 0) wr(1'b0, count + 16'd4);
         step();
      end
      cnt_en = 1'b1;

      // R1 wrap in off mode sets overflow
      wr(1'b1, 16'h0000);
      for (int i = 0; i < 70000 && !ovf_flag; i++) step();
      chk("R1 overflow on wrap", int'(ovf_flag), 1);
      ovf_clr = 1'b1; step(); ovf_clr = 1'b0;

      // R9 full-scale trigger never sets overflow
      wr(1'b0, 16'hFFFF);
      wr(1'b1, 16'h000B);
      conv_en = 1'b1;
      first = 0;
      for (int i = 0; i < 70000 && first == 0; i++) begin
         step();
         if (conv_start) first = 1;
      end
      chk("R9 trigger seen", first, 1);
      step(3);
      chk("R9 no overflow from trigger", int'(ovf_flag), 0);
      step(5);
      finish_run();
   end

endmodule